// File: doc/BRIEF.md
# Disk Flux Byte Serializer

This block sits between a magnetic disk head and a byte-wide processor port. When reading, it turns single-cycle flux-transition pulses into bit cells, packs the bits into bytes and raises a byte-ready flag for each finished byte. It also watches for long runs of one bits, which mark the start of a frame, and restarts its byte framing when it sees one. When writing, it shifts bytes out of its shift register as one-cycle flux-reversal pulses, at a bit rate set by a two-bit speed-zone input.

One controller, built around a three-state machine, owns the framing. The states are `LS_READ`, `LS_SYNC` and `LS_WRITE`. `LS_READ` moves to `LS_SYNC` (the run-hit transition) when the run of consecutive ones reaches the sync length. `LS_SYNC` goes back to `LS_READ` (the run-broken transition) on the first zero bit. Either read state moves to `LS_WRITE` (the enter-write transition) while `wr_mode` is high. `LS_WRITE` goes back to `LS_READ` (the leave-write transition) when `wr_mode` falls.

The bit-cell period is 16 minus the zone, counted in `clk` cycles. `clk` is the 16x base clock. In read mode each flux pulse moves the cell phase to half a period, so that the bit is sampled near the middle of the cell. If no pulse comes, a zero is produced once per period.

Top module: `flux_byte_link`

## Requirements
- R1: While `rst` is high, and just after it is released, `byte_rdy`, `overrun`, `sync_det` and `flux_out` are 0 and `dout` is 0x00.
- R2: The cell period P is 16 − `zone` clock cycles. In read mode, a `flux_in` pulse starts a 1-bit cell that is sampled P−P/2 cycles later (P/2 rounded down). Each further P cycles without a pulse produce a 0 bit, and no bit is sampled in the cycle right after a pulse.
- R3: In read mode, bits enter the shift register at the least significant end, so the first bit received becomes bit 7. When the 8th bit of a frame is sampled, `dout` takes the byte and `byte_rdy` rises on that same clock edge.
- R4: `sync_det` rises on the sample of the 10th consecutive 1 bit. A run of 9 ones leaves it low.
- R5: While `sync_det` is high, the bit count stays at zero and no byte completes. The 0 bit that ends the run clears `sync_det` and becomes bit 7 of the next byte.
- R6: While `sync_det` is high, `dout` follows the shift register on every sampled bit, so it reads 0xFF after a sync run.
- R7: `byte_rdy` stays high until a one-cycle `byte_ack`. The acknowledge clears both `byte_rdy` and `overrun`.
- R8: `overrun` is set when a byte completes while `byte_rdy` is still high and no acknowledge arrives in that cycle. A byte boundary sets `byte_rdy` in both modes.
- R9: In write mode the bit cells run freely with period P. Each 1 bit gives one `flux_out` pulse, one cycle wide, at the start of its cell, and a 0 bit gives none. Bits go out most significant first.
- R10: On entering write mode, the bits still in the shift register are sent first. At each byte boundary, `din` is loaded as the next byte to send.
- R11: `sync_det` stays low while write mode is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16x base clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_mode | input | 1 | 1 = write to the medium, 0 = read |
| zone | input | 2 | Speed zone; selects a cell period of 16 − zone cycles |
| flux_in | input | 1 | One-cycle pulse for each flux transition read from the head |
| flux_out | output | 1 | One-cycle flux-reversal pulse sent to the head |
| din | input | 8 | Byte to write, taken at each byte boundary |
| dout | output | 8 | Last byte read, or the live shift register during sync |
| byte_rdy | output | 1 | A byte boundary has passed and has not been acknowledged |
| byte_ack | input | 1 | One-cycle acknowledge of `byte_rdy` |
| overrun | output | 1 | A byte completed while `byte_rdy` was still set |
| sync_det | output | 1 | Sync run of 10 or more ones is in progress |

## Verification
An error in the bit count or in the sync state changes the byte framing. `dout` then shows rotated bytes on the very next byte boundary after a sync run, and `byte_rdy` appears one or more cells early or late. A wrong cell-phase counter shows up at the ports within a single cell: `flux_out` pulses fall off the P-cycle grid, or zero cells read as missing or extra bits. The bench therefore checks byte values and flags exactly at the cells where they must change.

// File: rtl/flux_link_pkg.sv
package flux_link_pkg;

    typedef enum logic [1:0] {
        LS_READ  = 2'd0,
        LS_SYNC  = 2'd1,
        LS_WRITE = 2'd2
    } link_state_e;

    // Cell length in base ticks for a given speed zone.
    function automatic int unsigned cell_period(input int unsigned base, input logic [1:0] zone);
        return base - 32'(zone);
    endfunction

endpackage

// File: rtl/flux_cell_clock.sv
module flux_cell_clock
    import flux_link_pkg::*;
#(
    parameter int BASE_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_mode,
    input  logic [1:0] zone,
    input  logic       flux_in,
    output logic       bit_stb,
    output logic       bit_val
);
    localparam int CW = $clog2(BASE_TICKS);

    logic [CW-1:0] phase_q;
    logic [CW-1:0] period_m1;
    logic [CW-1:0] half_cell;
    logic          pend_q;
    logic          at_end;
    logic          edge_seen;

    always_comb begin
        period_m1 = CW'(cell_period(BASE_TICKS, zone) - 1);
        half_cell = CW'(cell_period(BASE_TICKS, zone) >> 1);
        at_end    = (phase_q >= period_m1);
        edge_seen = !wr_mode && flux_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            pend_q  <= 1'b0;
        end else if (edge_seen) begin
            phase_q <= half_cell;
            pend_q  <= 1'b1;
        end else if (at_end) begin
            phase_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign bit_stb = at_end && !edge_seen;
    assign bit_val = pend_q && !wr_mode;

    // R2: cells are many ticks long, so two samples are never adjacent
    assert_stb_spaced_R2: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);
    // R2: a transition re-phases the cell, no sample right after it
    assert_rephase_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_mode && flux_in) |=> !bit_stb);

endmodule

// File: rtl/flux_frame_engine.sv
module flux_frame_engine
    import flux_link_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SYNC_RUN = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mode,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              byte_done,
    output logic              sync_det,
    output logic              flux_out
);
    localparam int BC_W  = $clog2(DATA_W);
    localparam int RUN_W = $clog2(SYNC_RUN + 1);

    link_state_e       state_q, state_d;
    logic [DATA_W-1:0] sreg_q;
    logic [DATA_W-1:0] shifted_in;
    logic [BC_W-1:0]   bcnt_q;
    logic [RUN_W-1:0]  run_q, run_next;
    logic              last_bit;
    logic              run_full;

    always_comb begin
        if (!bit_val)
            run_next = '0;
        else if (run_q >= RUN_W'(SYNC_RUN))
            run_next = run_q;
        else
            run_next = run_q + 1'b1;
        run_full   = (run_next >= RUN_W'(SYNC_RUN));
        last_bit   = (bcnt_q == BC_W'(DATA_W - 1));
        shifted_in = {sreg_q[DATA_W-2:0], bit_val};
        byte_done  = bit_stb && last_bit && (wr_mode || !run_full);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_READ: begin
                if (wr_mode)                    state_d = LS_WRITE; // enter-write
                else if (bit_stb && run_full)   state_d = LS_SYNC;  // run-hit
            end
            LS_SYNC: begin
                if (wr_mode)                    state_d = LS_WRITE; // enter-write
                else if (bit_stb && !bit_val)   state_d = LS_READ;  // run-broken
            end
            LS_WRITE: begin
                if (!wr_mode)                   state_d = LS_READ;  // leave-write
            end
            default:                            state_d = LS_READ;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= LS_READ;
        else     state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) flux_out <= 1'b0;
        else     flux_out <= wr_mode && bit_stb && sreg_q[DATA_W-1];
    end
    assign sync_det = (state_q == LS_SYNC);

    // shift register, bit count and run counter
    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q  <= '0;
            bcnt_q  <= '0;
            run_q   <= '0;
            rd_data <= '0;
        end else if (wr_mode) begin
            run_q <= '0;
            if (bit_stb) begin
                sreg_q <= last_bit ? wr_data : {sreg_q[DATA_W-2:0], 1'b0};
                bcnt_q <= last_bit ? '0 : bcnt_q + 1'b1;
            end
        end else if (bit_stb) begin
            run_q  <= run_next;
            sreg_q <= shifted_in;
            if (run_full) begin
                bcnt_q  <= '0;
                rd_data <= shifted_in;
            end else begin
                bcnt_q <= last_bit ? '0 : bcnt_q + 1'b1;
                if (last_bit) rd_data <= shifted_in;
            end
        end
    end

    // R5: framing is frozen during a sync run
    assert_no_byte_in_sync_R5: assert property (@(posedge clk) disable iff (rst)
        sync_det |-> !byte_done);
    // R4: sync only begins on a sampled 1 bit
    assert_sync_on_one_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_det) |-> $past(bit_val));
    // R9: every flux reversal is a single cycle
    assert_pulse_width_R9: assert property (@(posedge clk) disable iff (rst)
        flux_out |=> !flux_out);
    // R11: no sync indication while writing
    assert_quiet_sync_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_mode && $past(wr_mode)) |-> !sync_det);

endmodule

// File: rtl/flux_ready_flag.sv
module flux_ready_flag (
    input  logic clk,
    input  logic rst,
    input  logic byte_done,
    input  logic ack,
    output logic ready,
    output logic overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ready   <= 1'b0;
            overrun <= 1'b0;
        end else if (byte_done) begin
            ready <= 1'b1;
            if (ack)        overrun <= 1'b0;
            else if (ready) overrun <= 1'b1;
        end else if (ack) begin
            ready   <= 1'b0;
            overrun <= 1'b0;
        end
    end

    // R8: an overrun is only ever reported alongside a pending byte
    assert_overrun_has_ready_R8: assert property (@(posedge clk) disable iff (rst)
        overrun |-> ready);
    // R7: an acknowledge with no new byte drops the flag
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (ack && !byte_done) |=> (!ready && !overrun));

endmodule

// File: rtl/flux_byte_link.sv
module flux_byte_link
    import flux_link_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BASE_TICKS = 16,
    parameter int SYNC_RUN   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mode,
    input  logic [1:0]        zone,
    input  logic              flux_in,
    output logic              flux_out,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              byte_rdy,
    input  logic              byte_ack,
    output logic              overrun,
    output logic              sync_det
);
    logic bit_stb;
    logic bit_val;
    logic byte_done;

    flux_cell_clock #(.BASE_TICKS(BASE_TICKS)) u_clock (
        .clk     (clk),
        .rst     (rst),
        .wr_mode (wr_mode),
        .zone    (zone),
        .flux_in (flux_in),
        .bit_stb (bit_stb),
        .bit_val (bit_val)
    );

    flux_frame_engine #(.DATA_W(DATA_W), .SYNC_RUN(SYNC_RUN)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .wr_mode   (wr_mode),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .wr_data   (din),
        .rd_data   (dout),
        .byte_done (byte_done),
        .sync_det  (sync_det),
        .flux_out  (flux_out)
    );

    flux_ready_flag u_ready (
        .clk       (clk),
        .rst       (rst),
        .byte_done (byte_done),
        .ack       (byte_ack),
        .ready     (byte_rdy),
        .overrun   (overrun)
    );

endmodule

// File: tb/flux_byte_link_test.sv
`timescale 1ns/1ps
module flux_byte_link_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_mode = 1'b0;
    logic [1:0] zone = 2'd0;
    logic       flux_in = 1'b0;
    logic [7:0] din = 8'h00;
    logic       byte_ack = 1'b0;
    logic [7:0] dout;
    logic       flux_out, byte_rdy, overrun, sync_det;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int t0, bad, per;
    logic [15:0] got;

    // {zone, byte}; every byte starts with a 0 so it frames right after sync
    localparam logic [9:0] VEC [6] = '{
        {2'd0, 8'h52}, {2'd1, 8'h2D}, {2'd2, 8'h20},
        {2'd3, 8'h4B}, {2'd3, 8'h01}, {2'd1, 8'h6E}
    };

    always #2 clk = ~clk;

    flux_byte_link uut (
        .clk(clk), .rst(rst), .wr_mode(wr_mode), .zone(zone),
        .flux_in(flux_in), .flux_out(flux_out), .din(din), .dout(dout),
        .byte_rdy(byte_rdy), .byte_ack(byte_ack), .overrun(overrun),
        .sync_det(sync_det)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bit cell of the current zone; optional ack in its first cycle
    task automatic send_bit(input bit b, input bit ack);
        @(negedge clk); flux_in = b; byte_ack = ack;
        @(negedge clk); flux_in = 1'b0; byte_ack = 1'b0;
        repeat (16 - int'(zone) - 2) @(negedge clk);
    endtask

    task automatic send_sync();
        repeat (12) send_bit(1'b1, 1'b0);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit ack_first);
        for (int i = 7; i >= 0; i--) send_bit(v[i], ack_first && (i == 7));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: values held by reset
        check("R1 byte_rdy", byte_rdy, 0);
        check("R1 overrun", overrun, 0);
        check("R1 sync_det", sync_det, 0);
        check("R1 flux_out", flux_out, 0);
        check("R1 dout", dout, 8'h00);

        // R2/R3/R5/R6: table-driven reads across zones
        for (int i = 0; i < 6; i++) begin
            zone = VEC[i][9:8];
            send_sync();
            check("R4 sync after run", sync_det, 1);
            check("R6 dout during sync", dout, 8'hFF);
            send_byte(VEC[i][7:0], 1'b1);
            check("R3 byte_rdy", byte_rdy, 1);
            check("R2 R3 dout byte", dout, VEC[i][7:0]);
            check("R5 sync cleared", sync_det, 0);
            check("R7 no overrun after ack", overrun, 0);
        end

        // R4 boundary: nine ones do not sync, ten do
        zone = 2'd1;
        send_sync();
        send_bit(1'b0, 1'b1);
        repeat (7) send_bit(1'b1, 1'b0);
        check("R3 dout 7F", dout, 8'h7F);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        check("R4 nine ones no sync", sync_det, 0);
        send_bit(1'b1, 1'b0);
        check("R4 tenth one syncs", sync_det, 1);

        // R8/R7: overrun and acknowledge
        send_byte(8'h5A, 1'b1);
        send_byte(8'h24, 1'b0);
        check("R8 byte_rdy held", byte_rdy, 1);
        check("R8 overrun set", overrun, 1);
        check("R3 dout second byte", dout, 8'h24);
        @(negedge clk); byte_ack = 1'b1;
        @(negedge clk); byte_ack = 1'b0;
        check("R7 ack clears ready", byte_rdy, 0);
        check("R7 ack clears overrun", overrun, 0);

        // R9/R10/R11: echo then write in zone 2
        zone = 2'd2;
        per = 14;
        send_sync();
        send_byte(8'h52, 1'b1);
        send_byte(8'hB4, 1'b1);
        check("R3 dout B4", dout, 8'hB4);
        wr_mode = 1'b1; din = 8'hC3; byte_ack = 1'b1;
        @(negedge clk); byte_ack = 1'b0;
        t0 = -1; bad = 0; got = '0;
        for (int c = 0; c < 20 * 14; c++) begin
            @(negedge clk);
            if (flux_out) begin
                if (t0 < 0) t0 = c;
                if (((c - t0) % per) != 0) bad++;
                else if (((c - t0) / per) < 16) got[15 - ((c - t0) / per)] = 1'b1;
            end
        end
        check("R10 echo then din", got, 16'hB4C3);
        check("R9 pulses on cell grid", bad, 0);
        check("R10 byte_rdy on load", byte_rdy, 1);
        check("R8 overrun from unacked loads", overrun, 1);
        check("R11 no sync in write", sync_det, 0);
        wr_mode = 1'b0;

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule